// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Controller with Mode-Fault Guard

This block moves one byte at a time over a four-wire serial peripheral link, sending and receiving in the same transfer. It can run as the clock-owning master or as a slave clocked from outside. Clock idle level and sampling phase are chosen in software, which gives four transfer formats. Bits travel most significant first.

As master, the serial clock comes from a 5-bit prescaler with four rates: system clock divided by 4, 8, 16 or 32. As slave, the select, clock and data inputs pass through a two-flop synchronizer, and the shifter steps on the edges it detects there. Status flags report a finished byte, which also drives the interrupt line. They also report a data write that arrived while a byte was moving; that write is thrown away. The third flag reports a mode fault: another device pulled select low while this unit was master. A fault clears the master bit and turns off every output enable, so the external tri-state buffers release the lines.

Software uses a small register port: a 2-bit address, a write strobe, write data and combinational read data.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1) and the receive register (address 2) read 0. `irq` and every output enable are low, and `ss_n_o` is high.
- R2: With control bit 0 (enable) and bit 1 (master) set, a write to address 2 starts a transfer. The written byte goes out on `mosi_o` MSB first. The 8 bits sampled from `miso_i` are latched into the receive register (read at address 2) when the byte completes.
- R3: Control bits [5:4] select the master rate. Consecutive `sck_o` edges are 2, 4, 8 or 16 system clocks apart for codes 0 to 3, so the serial clock period is clk/4, clk/8, clk/16 or clk/32.
- R4: Control bit 2 sets the idle level of `sck_o`. With control bit 3 clear, data is sampled on the leading clock edge and changed on the trailing edge. With bit 3 set, data is changed on the leading edge and sampled on the trailing edge.
- R5: When a transfer completes, status bit 0 is set and `irq` goes high. Writing 1 to status bit 0 clears both.
- R6: A write to address 2 while a byte is in progress sets status bit 1 and is discarded. The byte on the wire and the byte received are unchanged.
- R7: If `ss_n_i` is low while enable and master are set, status bit 2 is set and control bit 1 is cleared. While status bit 2 is set, `sck_oe`, `mosi_oe` and `miso_oe` are all low.
- R8: With enable set and master clear, while `ss_n_i` is low the block shifts on the edges of `sck_i`. It returns the byte last written to address 2 on `miso_o`, with `miso_oe` high. The byte taken from `mosi_i` is latched into the receive register after the sixteenth clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Transfer-complete interrupt request |
| sck_i | input | 1 | Serial clock input (slave) |
| ss_n_i | input | 1 | Active-low select input |
| mosi_i | input | 1 | Serial data input in slave mode |
| miso_i | input | 1 | Serial data input in master mode |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| ss_n_o | output | 1 | Active-low select driven during a master byte |
| mosi_o | output | 1 | Serial data output in master mode |
| mosi_oe | output | 1 | Master data driver enable |
| miso_o | output | 1 | Serial data output in slave mode |
| miso_oe | output | 1 | Slave data driver enable |

## Verification
Master transfers are run in all four polarity/phase formats, each at a different prescaler rate. The bench acts as a slave and returns a byte of its own. Distinct and asymmetric byte patterns (0xA5/0x3C, 0x81/0x7E, 0x01/0x80, 0xF0/0x0F) show whether bit order or the sampling edge is wrong, and the measured edge spacing shows whether the rate decode is wrong. A write in the middle of a byte separates a discarded write from one that corrupts the shifter. Driving select low under master mode shows whether the fault path releases the drivers and demotes the unit. Slave transfers in two formats show whether the synchronized edge detection counts edges and picks the sampling edge correctly.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DATA_W = 8;
  localparam int PRE_W  = 5;
  localparam int EDGE_W = $clog2(2 * DATA_W);

  typedef logic [EDGE_W-1:0] edge_idx_t;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       mstr;
    logic       en;
  } ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // system clocks between serial clock edges for a rate code
  function automatic logic [PRE_W-1:0] half_period(input logic [1:0] rate);
    return PRE_W'(2) << rate;
  endfunction

  // edge numbers count from 0; even numbers are leading edges
  function automatic logic is_sample(input edge_idx_t idx, input logic cpha);
    return idx[0] == cpha;
  endfunction

  function automatic logic is_shift(input edge_idx_t idx, input logic cpha);
    return (idx[0] != cpha) && !(cpha && idx == '0);
  endfunction
endpackage

// File: rtl/spi_prescaler.sv
module spi_prescaler
  import spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = run && (cnt == half_period(rate) - PRE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                cnt <= cnt + PRE_W'(1);
  end

  // two ticks never sit back to back: the fastest rate still has a 2-cycle gap
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              active,
  input  logic              edge_p,
  input  logic              cpha,
  input  logic              in_bit,
  output logic              out_bit,
  output logic [DATA_W-1:0] rx_byte,
  output logic              last_edge
);
  logic [DATA_W-1:0] tx_sr, rx_sr;
  edge_idx_t         idx;
  logic              smp_now;

  assign smp_now   = active && edge_p && is_sample(idx, cpha);
  assign out_bit   = tx_sr[DATA_W-1];
  assign last_edge = active && edge_p && (idx == '1);
  assign rx_byte   = smp_now ? {rx_sr[DATA_W-2:0], in_bit} : rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
      idx   <= '0;
    end else if (load) begin
      tx_sr <= load_byte;
      idx   <= '0;
    end else if (!active) begin
      idx   <= '0;
    end else if (edge_p) begin
      if (is_sample(idx, cpha)) rx_sr <= {rx_sr[DATA_W-2:0], in_bit};
      if (is_shift(idx, cpha))  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end

  // a new byte is only loaded between transfers, with the edge count at rest
  p_load_at_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (idx == '0 && !edge_p));
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sck_i,
  input  logic       ss_n_i,
  input  logic       mosi_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       sck_oe,
  output logic       ss_n_o,
  output logic       mosi_o,
  output logic       mosi_oe,
  output logic       miso_o,
  output logic       miso_oe
);
  localparam int FLAG_W = 3;

  ctrl_t             ctrl_q;
  logic [FLAG_W-1:0] flags, flags_nx;   // {modf, wcol, done}
  logic              busy_m, phase;
  logic [DATA_W-1:0] rx_reg, rx_byte;
  logic [2:0]        sy1, sy2;          // {sck, ss_n, mosi}
  logic              sck_d;

  // named internal events
  logic ss_act, slave_act, in_prog, modf_ev, wr_data, wcol_ev, load, start;
  logic tick, m_edge, s_edge, edge_p, in_bit, shift_out, xfer_done, drive_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1   <= 3'b010;
      sy2   <= 3'b010;
      sck_d <= 1'b0;
    end else begin
      sy1   <= {sck_i, ss_n_i, mosi_i};
      sy2   <= sy1;
      sck_d <= sy2[2];
    end
  end

  assign ss_act    = !sy2[1];
  assign slave_act = ctrl_q.en && !ctrl_q.mstr && ss_act;
  assign modf_ev   = ctrl_q.en && ctrl_q.mstr && ss_act;
  assign in_prog   = busy_m || slave_act;
  assign wr_data   = reg_wr && (reg_addr == A_DATA);
  assign wcol_ev   = wr_data && in_prog;
  assign load      = wr_data && !in_prog;
  assign start     = load && ctrl_q.en && ctrl_q.mstr && !modf_ev;
  assign m_edge    = busy_m && tick;
  assign s_edge    = slave_act && (sy2[2] != sck_d);
  assign edge_p    = m_edge || s_edge;
  assign in_bit    = busy_m ? miso_i : sy2[0];

  spi_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(busy_m), .rate(ctrl_q.rate), .tick(tick)
  );

  spi_shift_engine u_eng (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(reg_wdata),
    .active(in_prog), .edge_p(edge_p), .cpha(ctrl_q.cpha), .in_bit(in_bit),
    .out_bit(shift_out), .rx_byte(rx_byte), .last_edge(xfer_done)
  );

  always_comb begin
    flags_nx = flags;
    if (reg_wr && reg_addr == A_STAT) flags_nx = flags & ~reg_wdata[FLAG_W-1:0];
    if (xfer_done) flags_nx[0] = 1'b1;
    if (wcol_ev)   flags_nx[1] = 1'b1;
    if (modf_ev)   flags_nx[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flags  <= '0;
      busy_m <= 1'b0;
      phase  <= 1'b0;
      rx_reg <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[5:0]);
      if (modf_ev) ctrl_q.mstr <= 1'b0;
      flags <= flags_nx;
      if (modf_ev)        busy_m <= 1'b0;
      else if (start)     busy_m <= 1'b1;
      else if (xfer_done) busy_m <= 1'b0;
      if (modf_ev || !busy_m) phase <= 1'b0;
      else if (m_edge)        phase <= ~phase;
      if (xfer_done) rx_reg <= rx_byte;
    end
  end

  assign drive_m = ctrl_q.en && ctrl_q.mstr && !flags[2];
  assign sck_o   = ctrl_q.cpol ^ phase;
  assign sck_oe  = drive_m;
  assign mosi_o  = shift_out;
  assign mosi_oe = drive_m;
  assign ss_n_o  = !busy_m;
  assign miso_o  = shift_out;
  assign miso_oe = slave_act && !flags[2];
  assign irq     = flags[0];

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, ctrl_q};
      A_STAT:  reg_rdata = {5'b0, flags};
      A_DATA:  reg_rdata = rx_reg;
      default: reg_rdata = '0;
    endcase
  end

  p_done_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> irq);

  p_wcol_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_ev |=> reg_rdata_flag_wcol());

  p_modf_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    modf_ev |=> (!ctrl_q.mstr && !sck_oe && !mosi_oe && !miso_oe && !busy_m));

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_m |-> (sck_o == ctrl_q.cpol));

  p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mosi_oe && miso_oe));

  function automatic logic reg_rdata_flag_wcol();
    return flags[1];
  endfunction
endmodule

// File: tb/spi_xcvr_test.sv
module spi_xcvr_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic       irq;
  logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
  logic       sck_o, sck_oe, ss_n_o, mosi_o, mosi_oe, miso_o, miso_oe;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  logic irq_prev = 1'b0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_xcvr uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_o(ss_n_o), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd2;
  endtask

  // monitor: each rising irq pops the expected received byte
  always @(negedge clk) begin
    if (irq && !irq_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R2/R8 unexpected completion", reg_rdata, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(reg_rdata == e, "R2/R8 received byte", reg_rdata, e);
      end
    end
    irq_prev = irq;
  end

  task automatic wait_done(input string req);
    int g = 0;
    while (!irq && g < 200) begin @(negedge clk); g++; end
    check(irq == 1'b1, req, irq, 1);
    repeat (2) @(negedge clk);
    reg_write(2'd1, 8'h01);
    #1 check(irq == 1'b0, "R5 irq cleared by writing 1", irq, 0);
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb,
                             input bit cpol, input bit cpha, input logic [1:0] rate,
                             input bit collide);
    int k = 0, cyc = 0, n = 0, guard = 0, bad = 0;
    logic prev;
    logic [7:0] got = 8'h00, st;
    bit pend = 0;
    reg_write(2'd0, {2'b00, rate, cpha, cpol, 1'b1, 1'b1});
    #1 check(sck_o == cpol, "R4 idle clock level", sck_o, cpol);
    miso_i = sb[7];
    exp_q.push_back(sb);
    prev = sck_o;
    reg_write(2'd2, tx);
    cyc = 1;
    while (k < 16 && guard < 2000) begin
      @(negedge clk); guard++; cyc++;
      if (pend) begin reg_wr = 1'b0; pend = 0; end
      if (sck_o != prev) begin
        prev = sck_o;
        if (k > 0 && cyc != (2 << rate)) bad++;
        cyc = 0;
        if ((k & 1) == int'(cpha)) got = {got[6:0], mosi_o};
        else if (!(cpha && k == 0)) begin n++; if (n < 8) miso_i = sb[7-n]; end
        if (collide && k == 4) begin reg_addr = 2'd2; reg_wdata = 8'h00; reg_wr = 1'b1; pend = 1; end
        k++;
      end
    end
    if (pend) reg_wr = 1'b0;
    check(k == 16, "R2 sixteen clock edges", k, 16);
    check(bad == 0, "R3 edge spacing for rate code", bad, 0);
    check(got == tx, "R2/R4 byte on mosi MSB first", got, tx);
    wait_done("R5 irq after master byte");
    if (collide) begin
      reg_read(2'd1, st);
      check(st[1] == 1'b1, "R6 collision flag", st, 8'h02);
      reg_write(2'd1, 8'h02);
    end
  endtask

  task automatic slave_xfer(input logic [7:0] mb, input logic [7:0] db,
                            input bit cpol, input bit cpha);
    int n = 0;
    logic [7:0] got = 8'h00;
    sck_i = cpol;
    reg_write(2'd0, {4'b0000, cpha, cpol, 1'b0, 1'b1});
    reg_write(2'd2, db);
    exp_q.push_back(mb);
    mosi_i = mb[7];
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    check(miso_oe == 1'b1, "R8 slave driver enabled", miso_oe, 1);
    for (int k = 0; k < 16; k++) begin
      if ((k & 1) == int'(cpha)) got = {got[6:0], miso_o};
      else if (!(cpha && k == 0)) begin n++; if (n < 8) mosi_i = mb[7-n]; end
      sck_i = ~sck_i;
      repeat (8) @(negedge clk);
    end
    check(got == db, "R8 byte returned on miso", got, db);
    wait_done("R5 irq after slave byte");
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, v); check(v == 8'h00, "R1 control reset", v, 0);
    reg_read(2'd1, v); check(v == 8'h00, "R1 status reset", v, 0);
    reg_read(2'd2, v); check(v == 8'h00, "R1 data reset", v, 0);
    check({irq, sck_oe, mosi_oe, miso_oe} == 4'b0, "R1 irq and enables low",
          {irq, sck_oe, mosi_oe, miso_oe}, 0);
    check(ss_n_o == 1'b1, "R1 select idle high", ss_n_o, 1);

    master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 2'd0, 1'b0);
    master_xfer(8'h81, 8'h7E, 1'b0, 1'b1, 2'd1, 1'b0);
    master_xfer(8'h01, 8'h80, 1'b1, 1'b0, 2'd2, 1'b0);
    master_xfer(8'hF0, 8'h0F, 1'b1, 1'b1, 2'd3, 1'b0);
    // R6: mid-byte write must not disturb this transfer
    master_xfer(8'hC3, 8'h5A, 1'b0, 1'b0, 2'd3, 1'b1);

    // R7: mode fault
    reg_write(2'd0, 8'h03);
    check(sck_oe == 1'b1, "R7 master drives before fault", sck_oe, 1);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    reg_read(2'd1, v); check(v[2] == 1'b1, "R7 fault flag", v, 8'h04);
    reg_read(2'd0, v); check(v[1] == 1'b0, "R7 master bit cleared", v, 8'h01);
    check({sck_oe, mosi_oe, miso_oe} == 3'b0, "R7 drivers released",
          {sck_oe, mosi_oe, miso_oe}, 0);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    reg_write(2'd1, 8'h04);

    slave_xfer(8'h96, 8'h4B, 1'b0, 1'b0);
    slave_xfer(8'h2D, 8'hE1, 1'b1, 1'b1);

    check(exp_q.size() == 0, "R2/R8 all completions seen", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule